// File: doc/BRIEF.md
# Narrow Flash Fetch Bridge

The bridge connects a 32-bit core-side read port to a program store that is only 16 bits wide and answers one half-word per clock, one cycle after the read is issued. A 32-bit request is split into two half-word reads at consecutive half-word addresses. The lower half comes first and the two halves are joined little-endian. A 16-bit request needs a single read and is returned zero-extended.

Every request class has a fixed, exact cycle count. Instruction fetches run their reads at once. Data loads are padded with idle (dead) cycles on the flash port before and after the reads. A multi-word load of N words spends N dead cycles before its 2×N reads and N cycles after. The core raises a request and holds it until it sees `ready_o`, which pulses for one cycle per delivered word. A new request is taken only while the bridge is idle.

Top module: `nfb_bridge`

## Requirements
- R1: While `rst_n` is low, `ready_o` and `fl_en_o` are low, even when a request is presented or an operation was in progress. After reset the bridge is idle and takes a request in any cycle where `req_i` is high.
- R2: Op code 0 (word fetch): reads are issued in the first and second cycle after the accepting cycle, at half-word indices {addr[19:2],0} and that index plus one. `ready_o` rises in the third cycle, and `rdata_o` = {second half, first half}.
- R3: Op code 1 (half fetch): one read at half-word index addr[19:1] in the first cycle after acceptance. `ready_o` rises in the second cycle with `rdata_o` = {16'h0000, half}.
- R4: Op code 2 (word load): one dead cycle with `fl_en_o` low, then two reads as in R2. `ready_o` rises in the fourth cycle after acceptance, which is also the trailing dead cycle.
- R5: Op code 3 (half load): one dead cycle, one read as in R3, and `ready_o` in the third cycle after acceptance.
- R6: Op code 4 (multi-word load) with `len_i` = N-1 (N = 1..16): N dead cycles, then 2×N back-to-back reads starting at the aligned index. Word k is taken from byte address addr+4k, and its `ready_o` pulse falls in cycle N+3+2k after acceptance. `fl_en_o` is high in exactly 2×N cycles.
- R7: After the last `ready_o` pulse the bridge stays busy for N cycles (op 4) or one cycle (all other codes), counted from the pulse cycle itself. Only after that does it accept the next request.
- R8: `ready_o` is never high for two consecutive cycles. It is high only in the cycle after a read that completes a word or half-word, and it is low whenever the bridge has no request in progress.
- R9: The op code, address and length are sampled in the accepting cycle. Changing them while the request is in progress has no effect on timing or data.
- R10: Op codes 5 to 7 behave as op code 2, and `len_i` is ignored for them.
- R11: Within one request, reads in consecutive cycles use consecutive half-word indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until `ready_o` for the last word |
| op_i | input | 3 | Request class code |
| addr_i | input | ADDR_W | Byte address |
| len_i | input | LEN_W | Word count minus one for op code 4 |
| ready_o | output | 1 | One-cycle pulse: `rdata_o` is valid |
| rdata_o | output | 32 | Returned word or zero-extended half-word |
| fl_en_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W-1 | Flash half-word index |
| fl_rdata_i | input | 16 | Flash data, valid one cycle after the strobe |

## Verification
In a multi-word load, the `ready_o` pulse for word k falls in the same cycle that issues the low-half read of word k+1. The pulse for the last word shares its cycle with the first trailing dead cycle. The bench provokes this with bursts of 2, 4 and 16 words. It checks that every word carries the data of its own address and that the pulses are exactly two cycles apart, which would fail if the low-half latch were overwritten. The next request is raised in the very cycle of the final pulse, so the measured latency of that request shows whether the tail and the hand-back to idle overlap correctly.

// File: rtl/nfb_pkg.sv
`timescale 1ns/1ps
package nfb_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;

    localparam logic [2:0] OPC_FETCH_W = 3'd0;
    localparam logic [2:0] OPC_FETCH_H = 3'd1;
    localparam logic [2:0] OPC_LOAD_W  = 3'd2;
    localparam logic [2:0] OPC_LOAD_H  = 3'd3;
    localparam logic [2:0] OPC_LOAD_M  = 3'd4;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_DEAD_PRE = 2'd1,
        PH_ACCESS   = 2'd2,
        PH_TAIL     = 2'd3
    } phase_e;
endpackage

// File: rtl/nfb_plan.sv
`timescale 1ns/1ps
// Maps a request class to its dead, access and tail cycle counts.
module nfb_plan
    import nfb_pkg::*;
#(
    parameter int unsigned LEN_W = 4,
    parameter int unsigned CNT_W = LEN_W + 2
) (
    input  logic [2:0]       op_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] dead_pre_o,
    output logic [CNT_W-1:0] n_access_o,
    output logic [CNT_W-1:0] tail_o,
    output logic             half_o
);
    logic [CNT_W-1:0] words;

    always_comb begin
        words      = CNT_W'(len_i) + CNT_W'(1);
        dead_pre_o = '0;
        n_access_o = CNT_W'(2);
        tail_o     = CNT_W'(1);
        half_o     = 1'b0;
        case (op_i)
            OPC_FETCH_W: begin
                dead_pre_o = '0;
            end
            OPC_FETCH_H: begin
                n_access_o = CNT_W'(1);
                half_o     = 1'b1;
            end
            OPC_LOAD_H: begin
                dead_pre_o = CNT_W'(1);
                n_access_o = CNT_W'(1);
                half_o     = 1'b1;
            end
            OPC_LOAD_M: begin
                dead_pre_o = words;
                n_access_o = words << 1;
                tail_o     = words;
            end
            default: begin
                // word load and the spare codes
                dead_pre_o = CNT_W'(1);
            end
        endcase
    end
endmodule

// File: rtl/nfb_seq.sv
`timescale 1ns/1ps
// Phase sequencer: idle, leading dead cycles, reads, trailing cycles.
module nfb_seq
    import nfb_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned HAW    = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  dead_pre_i,
    input  logic [CNT_W-1:0]  n_access_i,
    input  logic [CNT_W-1:0]  tail_i,
    input  logic              half_i,
    output logic              fl_en_o,
    output logic [HAW-1:0]    fl_addr_o,
    output logic              acc_lo_o,
    output logic              acc_end_o,
    output logic              half_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] n_acc;
        logic [CNT_W-1:0] tail;
        logic [HAW-1:0]   ptr;
        logic             hi_next;
        logic             half;
    } seq_t;

    seq_t s_d, s_q;
    logic last_d;

    always_comb begin
        s_d    = s_q;
        last_d = (s_q.cnt == CNT_W'(1));
        case (s_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    s_d.n_acc   = n_access_i;
                    s_d.tail    = tail_i;
                    s_d.half    = half_i;
                    s_d.hi_next = 1'b0;
                    s_d.ptr     = half_i ? addr_i[ADDR_W-1:1]
                                         : {addr_i[ADDR_W-1:2], 1'b0};
                    if (dead_pre_i != '0) begin
                        s_d.phase = PH_DEAD_PRE;
                        s_d.cnt   = dead_pre_i;
                    end else begin
                        s_d.phase = PH_ACCESS;
                        s_d.cnt   = n_access_i;
                    end
                end
            end
            PH_DEAD_PRE: begin
                if (last_d) begin
                    s_d.phase = PH_ACCESS;
                    s_d.cnt   = s_q.n_acc;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_ACCESS: begin
                s_d.ptr     = s_q.ptr + HAW'(1);
                s_d.hi_next = ~s_q.hi_next;
                if (last_d) begin
                    s_d.phase = PH_TAIL;
                    s_d.cnt   = s_q.tail;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_TAIL: begin
                if (last_d) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign fl_en_o   = (s_q.phase == PH_ACCESS);
    assign fl_addr_o = s_q.ptr;
    assign acc_lo_o  = fl_en_o & ~s_q.half & ~s_q.hi_next;
    assign acc_end_o = fl_en_o & (s_q.half | s_q.hi_next);
    assign half_o    = s_q.half;
endmodule

// File: rtl/nfb_join.sv
`timescale 1ns/1ps
// Collects returning half-words and forms the core-side word and ready pulse.
module nfb_join
    import nfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_lo_i,
    input  logic              acc_end_i,
    input  logic              half_i,
    input  logic [HALF_W-1:0] fl_rdata_i,
    output logic              ready_o,
    output logic [WORD_W-1:0] rdata_o
);
    typedef struct packed {
        logic              got_lo;
        logic              got_end;
        logic              half;
        logic [HALF_W-1:0] lo;
    } join_t;

    join_t j_d, j_q;

    always_comb begin
        j_d         = j_q;
        j_d.got_lo  = acc_lo_i;
        j_d.got_end = acc_end_i;
        if (acc_end_i) j_d.half = half_i;
        if (j_q.got_lo) j_d.lo = fl_rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign ready_o = j_q.got_end;
    assign rdata_o = j_q.half ? {{HALF_W{1'b0}}, fl_rdata_i}
                              : {fl_rdata_i, j_q.lo};
endmodule

// File: rtl/nfb_bridge.sv
`timescale 1ns/1ps
module nfb_bridge
    import nfb_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ready_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic              fl_en_o,
    output logic [ADDR_W-2:0] fl_addr_o,
    input  logic [HALF_W-1:0] fl_rdata_i
);
    localparam int unsigned CNT_W = LEN_W + 2;
    localparam int unsigned HAW   = ADDR_W - 1;

    logic [CNT_W-1:0] dead_pre, n_access, tail;
    logic             plan_half, seq_half, acc_lo, acc_end;

    nfb_plan #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_plan (
        .op_i       (op_i),
        .len_i      (len_i),
        .dead_pre_o (dead_pre),
        .n_access_o (n_access),
        .tail_o     (tail),
        .half_o     (plan_half)
    );

    nfb_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HAW(HAW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .addr_i     (addr_i),
        .dead_pre_i (dead_pre),
        .n_access_i (n_access),
        .tail_i     (tail),
        .half_i     (plan_half),
        .fl_en_o    (fl_en_o),
        .fl_addr_o  (fl_addr_o),
        .acc_lo_o   (acc_lo),
        .acc_end_o  (acc_end),
        .half_o     (seq_half)
    );

    nfb_join u_join (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_lo_i   (acc_lo),
        .acc_end_i  (acc_end),
        .half_i     (seq_half),
        .fl_rdata_i (fl_rdata_i),
        .ready_o    (ready_o),
        .rdata_o    (rdata_o)
    );
endmodule

// File: rtl/nfb_checker.sv
`timescale 1ns/1ps
module nfb_checker #(
    parameter int unsigned HAW = 19
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ready,
    input logic           fl_en,
    input logic [HAW-1:0] fl_addr
);
    // R8: a pulse never lasts two cycles
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R8: a pulse only follows a flash read
    p_ready_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(fl_en));

    // R8: the final read of a run always yields a pulse
    p_run_end_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_en) |-> ready);

    // R11: back-to-back reads walk up by one half-word
    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && $past(fl_en)) |-> (fl_addr == HAW'($past(fl_addr) + 1'b1)));
endmodule

bind nfb_bridge nfb_checker #(.HAW(HAW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready_o),
    .fl_en   (fl_en_o),
    .fl_addr (fl_addr_o)
);

// File: tb/sim_nfb_bridge.sv
`timescale 1ns/1ps
module sim_nfb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  op = '0;
    logic [19:0] addr = '0;
    logic [3:0]  len = '0;
    logic        ready;
    logic [31:0] rdata;
    logic        fl_en;
    logic [18:0] fl_addr;
    logic [15:0] fl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [15:0] flash_val(input logic [18:0] h);
        return {h[7:0] ^ 8'hC3, h[7:0] ^ {h[11:8], h[15:12]}};
    endfunction

    function automatic logic [31:0] exp_data(input logic [2:0] o, input logic [19:0] a, input int k);
        logic [18:0] base;
        if (o == 3'd1 || o == 3'd3) return {16'h0000, flash_val(a[19:1])};
        base = {a[19:2], 1'b0} + 19'(2 * k);
        return {flash_val(base + 19'd1), flash_val(base)};
    endfunction

    // synchronous 16-bit flash model
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fl_rdata <= '0;
        else if (fl_en) fl_rdata <= flash_val(fl_addr);
    end

    nfb_bridge u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op), .addr_i(addr), .len_i(len),
        .ready_o(ready), .rdata_o(rdata), .fl_en_o(fl_en), .fl_addr_o(fl_addr),
        .fl_rdata_i(fl_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    // op, addr, len, first ready offset, words, tail, flash reads
    typedef struct packed {
        logic [2:0]  op;
        logic [19:0] addr;
        logic [3:0]  len;
        logic [5:0]  first;
        logic [4:0]  words;
        logic [5:0]  tail;
        logic [5:0]  acc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 20'h00100, 4'd0,  6'd3,  5'd1,  6'd1,  6'd2},
        '{3'd1, 20'h00102, 4'd0,  6'd2,  5'd1,  6'd1,  6'd1},
        '{3'd2, 20'h00208, 4'd0,  6'd4,  5'd1,  6'd1,  6'd2},
        '{3'd3, 20'h0020E, 4'd0,  6'd3,  5'd1,  6'd1,  6'd1},
        '{3'd4, 20'h00300, 4'd1,  6'd5,  5'd2,  6'd2,  6'd4},
        '{3'd0, 20'h00104, 4'd0,  6'd3,  5'd1,  6'd1,  6'd2},
        '{3'd4, 20'h00410, 4'd3,  6'd7,  5'd4,  6'd4,  6'd8},
        '{3'd1, 20'h00107, 4'd0,  6'd2,  5'd1,  6'd1,  6'd1},
        '{3'd4, 20'h00500, 4'd15, 6'd19, 5'd16, 6'd16, 6'd32},
        '{3'd4, 20'h00600, 4'd0,  6'd4,  5'd1,  6'd1,  6'd2},
        '{3'd6, 20'h0060C, 4'd0,  6'd4,  5'd1,  6'd1,  6'd2},
        '{3'd2, 20'h00212, 4'd0,  6'd4,  5'd1,  6'd1,  6'd2},
        '{3'd5, 20'h00620, 4'd7,  6'd4,  5'd1,  6'd1,  6'd2}
    };

    // Called at a negedge; drives the request and follows it to its last pulse.
    task automatic run_op(input logic [2:0] o, input logic [19:0] a, input logic [3:0] l,
                          input int first, input int words, input int acc, input string tag);
        int k = 0;
        int seen = 0;
        int last = 0;
        int n_en = 0;
        int exp_off;
        req = 1'b1; op = o; addr = a; len = l;
        while (seen < words && k < 400) begin
            @(negedge clk);
            k++;
            if (fl_en) n_en++;
            if (ready) begin
                exp_off = (seen == 0) ? first : last + 2;
                check(k == exp_off, {tag, " ready cycle (R7 on first)"}, 32'(k), 32'(exp_off));
                check(rdata == exp_data(o, a, seen), {tag, " data"}, rdata, exp_data(o, a, seen));
                seen++;
                last = k;
            end
        end
        check(seen == words, {tag, " word count"}, 32'(seen), 32'(words));
        check(n_en == acc, {tag, " flash reads"}, 32'(n_en), 32'(acc));
    endtask

    initial begin
        int prev_tail;
        int k;
        int first_en;
        int n_en;
        logic [18:0] first_addr;
        string tag;

        // R1: reset holds outputs low even with a request present
        req = 1'b1; op = 3'd4; len = 4'd3;
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R1 ready in reset", 32'(ready), 32'd0);
        check(fl_en == 1'b0, "R1 fl_en in reset", 32'(fl_en), 32'd0);
        req = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ready == 1'b0 && fl_en == 1'b0, "R1 idle after reset", {30'd0, ready, fl_en}, 32'd0);

        // table walk: each request raised in the cycle of the previous final pulse
        prev_tail = 0;
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                3'd0:    tag = "R2 word fetch";
                3'd1:    tag = "R3 half fetch";
                3'd2:    tag = "R4 word load";
                3'd3:    tag = "R5 half load";
                3'd4:    tag = "R6 burst";
                default: tag = "R10 spare code";
            endcase
            run_op(VECS[i].op, VECS[i].addr, VECS[i].len,
                   prev_tail + int'(VECS[i].first), int'(VECS[i].words), int'(VECS[i].acc), tag);
            prev_tail = int'(VECS[i].tail);
        end
        req = 1'b0;

        // R8: no pulse or read without a request
        n_en = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (ready || fl_en) n_en++;
        end
        check(n_en == 0, "R8 quiet when idle", 32'(n_en), 32'd0);

        // R9: fields changed after acceptance are ignored
        req = 1'b1; op = 3'd2; addr = 20'h00700; len = 4'd0;
        @(negedge clk);
        op = 3'd1; addr = 20'h00F00; len = 4'd9;
        k = 1; n_en = 0;
        if (fl_en) n_en++;
        while (!ready && k < 50) begin
            @(negedge clk);
            k++;
            if (fl_en) n_en++;
        end
        check(k == 4, "R9 ready cycle", 32'(k), 32'd4);
        check(rdata == exp_data(3'd2, 20'h00700, 0), "R9 data", rdata, exp_data(3'd2, 20'h00700, 0));
        check(n_en == 2, "R9 flash reads", 32'(n_en), 32'd2);
        req = 1'b0;
        repeat (3) @(negedge clk);

        // R6: dead cycles keep the strobe low; first read at the aligned index
        req = 1'b1; op = 3'd4; addr = 20'h00802; len = 4'd2;
        first_en = 0; n_en = 0; first_addr = '0;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            if (fl_en) begin
                if (n_en == 0) begin
                    first_en = c;
                    first_addr = fl_addr;
                end
                n_en++;
            end
            if (c == 10) req = 1'b0;
        end
        check(first_en == 4, "R6 dead cycles before reads", 32'(first_en), 32'd4);
        check(first_addr == 19'h00400, "R6 first index", 32'(first_addr), 32'h400);
        check(n_en == 6, "R6 read count", 32'(n_en), 32'd6);
        repeat (3) @(negedge clk);

        // R1: reset in the middle of a burst aborts it
        req = 1'b1; op = 3'd4; addr = 20'h00900; len = 4'd7;
        repeat (11) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(ready == 1'b0 && fl_en == 1'b0, "R1 abort in reset", {30'd0, ready, fl_en}, 32'd0);
        req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(3'd1, 20'h00A04, 4'd0, 2, 1, 1, "R1 R3 after abort");
        req = 1'b0;
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule